// File: doc/BRIEF.md
# Supply-Fault Reset Sequencer

This block turns two supply-monitor flags into one system reset. The first flag, `pwr_ok_a`, says the supply is above the power-on threshold. The second, `bor_ok_a`, says the supply is above the brown-out trip level. Both flags are asynchronous. Each one passes through a two-stage synchronizer that clears at once when its flag falls. A loss of either flag sets `sys_rst` immediately, without waiting for a clock edge. Reset is released only on a clock edge, and only after a chain of delays, counted in clock cycles, has run without a supply dip.

The sequencer has four states. In PWR_WAIT it waits for the power-on delay; the counter advances only while both synchronized flags are high. In BRN_WAIT it waits for the brown-out settle delay while the brown-out flag stays high. In PUP_TMR it runs the power-up timer. In RUN reset is released. The transitions are:
- PWR_WAIT to PUP_TMR when the power-on delay completes.
- BRN_WAIT to PUP_TMR when the settle delay completes.
- PUP_TMR to RUN when the timer completes.
- PUP_TMR to BRN_WAIT on a brown-out dip.
- RUN to BRN_WAIT on a brown-out dip.
- Any state to PWR_WAIT, asynchronously, when the power-on flag is lost.

A two-bit status register records the cause of each reset. Software reads it on `stat_rd` and clears bits through a write-zero port.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_ok_a` is low, `sys_rst` is 1. When `pwr_ok_a` rises with `bor_ok_a` already high, `sys_rst` first reads 0 after exactly T_POR+T_PWRT+3 rising clock edges: 2 edges of synchronizer, then the delays, then 1 edge of output register.
- R2: Loss of `pwr_ok_a` sets status bit 0 (power-on cause) to 1 and clears status bit 1 (brown-out cause), without waiting for a clock. `stat_rd[0]` is the power-on bit and `stat_rd[1]` is the brown-out bit.
- R3: A low level on `bor_ok_a` sets `sys_rst` to 1 at once, with no clock edge needed.
- R4: After a brown-out that started in RUN, `sys_rst` first reads 0 exactly T_BOR+T_PWRT+3 edges after `bor_ok_a` rises.
- R5: A brown-out dip during the synchronizer, BRN_WAIT or PUP_TMR restarts the whole chain. Release then comes T_BOR+T_PWRT+3 edges after the last rise of `bor_ok_a`.
- R6: A brown-out seen in RUN, or in PUP_TMR outside a power-on episode, sets status bit 1, even if software cleared it earlier in the same episode.
- R7: On a clock edge with `stat_wr_en` = 1, each status bit whose `stat_wr_data` bit is 0 is cleared, and each bit whose data bit is 1 keeps its value. A brown-out set on the same edge wins over a clear.
- R8: A brown-out dip during a power-on episode (from loss of `pwr_ok_a` until RUN) leaves status bit 1 at 0. A dip in PWR_WAIT restarts the power-on delay, so release comes T_POR+T_PWRT+3 edges after `bor_ok_a` rises.
- R9: Loss of `pwr_ok_a` in RUN asserts `sys_rst` at once and runs the full power-on sequence again.
- R10: Each delay parameter (T_POR, T_BOR, T_PWRT) is at least 1 clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock |
| pwr_ok_a | input | 1 | Asynchronous flag: supply above the power-on threshold |
| bor_ok_a | input | 1 | Asynchronous flag: supply above the brown-out trip level |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 2 | Write data; a 0 bit clears the matching status bit |
| stat_rd | output | 2 | Status: bit 0 is the power-on cause, bit 1 is the brown-out cause |
| sys_rst | output | 1 | Active-high system reset |

## Verification
The clocked properties are disabled while `pwr_ok_a` is low. They also take for granted that the two flags never change in the same instant as a clock edge, so each synchronizer delay is exactly two edges. The stimulus keeps to this rule: every flag, write strobe and data change is made on a falling clock edge, and outputs are sampled on the next falling edge. The brown-out sweep moves a one-cycle dip across every edge offset of the restart chain, so each offset meets that same timing rule.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_PWR_WAIT = 2'd0,
        ST_BRN_WAIT = 2'd1,
        ST_PUP_TMR  = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] q;

    // The chain clears at once when the flag drops and fills with ones on clock edges.
    always_ff @(posedge clk or negedge async_in) begin
        if (!async_in) q <= '0;
        else           q <= {q[STAGES-2:0], 1'b1};
    end

    assign sync_out = q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int T_POR  = 3,
    parameter int T_BOR  = 2,
    parameter int T_PWRT = 4
) (
    input  logic       clk,
    input  logic       pwr_a,
    input  logic       dip_n,
    input  logic       pwr_ok,
    input  logic       bor_ok,
    output logic       sys_rst,
    output logic       bor_evt,
    output seq_state_t state_o
);
    localparam int MAXD = (T_POR > T_BOR) ? ((T_POR > T_PWRT) ? T_POR : T_PWRT)
                                          : ((T_BOR > T_PWRT) ? T_BOR : T_PWRT);
    localparam int CW = $clog2(MAXD + 1);
    localparam logic [CW-1:0] LAST_POR  = CW'(T_POR - 1);
    localparam logic [CW-1:0] LAST_BOR  = CW'(T_BOR - 1);
    localparam logic [CW-1:0] LAST_PWRT = CW'(T_PWRT - 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          episode;
    logic          rst_q;

    initial begin
        assert (T_POR >= 1 && T_BOR >= 1 && T_PWRT >= 1)
            else $error("R10: every delay must be at least one cycle");
    end

    // Next state and counter.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        bor_evt = 1'b0;
        unique case (state)
            ST_PWR_WAIT: begin
                if (!pwr_ok || !bor_ok) begin
                    cnt_nxt = '0;
                end else if (cnt == LAST_POR) begin
                    nxt     = ST_PUP_TMR;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_BRN_WAIT: begin
                if (!bor_ok) begin
                    cnt_nxt = '0;
                end else if (cnt == LAST_BOR) begin
                    nxt     = ST_PUP_TMR;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_PUP_TMR: begin
                if (!bor_ok) begin
                    nxt     = ST_BRN_WAIT;
                    cnt_nxt = '0;
                    bor_evt = !episode;
                end else if (cnt == LAST_PWRT) begin
                    nxt     = ST_RUN;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_RUN: begin
                cnt_nxt = '0;
                if (!bor_ok) begin
                    nxt     = ST_BRN_WAIT;
                    bor_evt = 1'b1;
                end
            end
            default: begin
                nxt     = ST_PWR_WAIT;
                cnt_nxt = '0;
            end
        endcase
    end

    // State register: losing the power-on flag forces PWR_WAIT at once.
    always_ff @(posedge clk or negedge pwr_a) begin
        if (!pwr_a) begin
            state   <= ST_PWR_WAIT;
            cnt     <= '0;
            episode <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (nxt == ST_RUN) episode <= 1'b0;
        end
    end

    // Reset output: set immediately on any dip, cleared only on a clock edge.
    always_ff @(posedge clk or negedge dip_n) begin
        if (!dip_n) rst_q <= 1'b1;
        else        rst_q <= (state != ST_RUN);
    end

    assign sys_rst = rst_q;
    assign state_o = state;

    a_r5_restart_chain: assert property (@(posedge clk) disable iff (!pwr_a)
        (state == ST_PUP_TMR && !bor_ok) |=> (state == ST_BRN_WAIT));
    a_r4_run_entry: assert property (@(posedge clk) disable iff (!pwr_a)
        (state == ST_RUN) |-> ($past(state) == ST_RUN || $past(state) == ST_PUP_TMR));
    a_r1_hold_reset: assert property (@(posedge clk) disable iff (!pwr_a)
        (state != ST_RUN) |=> sys_rst);
    a_r8_no_bor_in_episode: assert property (@(posedge clk) disable iff (!pwr_a)
        (state == ST_PWR_WAIT) |-> !bor_evt);
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status (
    input  logic       clk,
    input  logic       pwr_a,
    input  logic       bor_evt,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] stat
);
    // Bit 0 is the power-on cause and bit 1 the brown-out cause; a set event beats a clear.
    always_ff @(posedge clk or negedge pwr_a) begin
        if (!pwr_a) begin
            stat <= 2'b01;
        end else begin
            stat[0] <= wr_en ? (stat[0] & wr_data[0]) : stat[0];
            stat[1] <= bor_evt | (wr_en ? (stat[1] & wr_data[1]) : stat[1]);
        end
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!pwr_a)
        bor_evt |=> stat[1]);
    a_r7_no_write_keeps: assert property (@(posedge clk) disable iff (!pwr_a)
        !wr_en |=> $stable(stat[0]));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int T_POR  = 3,
    parameter int T_BOR  = 2,
    parameter int T_PWRT = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       pwr_ok_a,
    input  logic       bor_ok_a,
    input  logic       stat_wr_en,
    input  logic [1:0] stat_wr_data,
    output logic [1:0] stat_rd,
    output logic       sys_rst
);
    logic       pwr_ok, bor_ok, bor_evt, dip_n;
    seq_state_t state;

    assign dip_n = pwr_ok_a & bor_ok_a;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync_pwr (
        .clk(clk), .async_in(pwr_ok_a), .sync_out(pwr_ok));
    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync_bor (
        .clk(clk), .async_in(bor_ok_a), .sync_out(bor_ok));

    rstseq_fsm #(.T_POR(T_POR), .T_BOR(T_BOR), .T_PWRT(T_PWRT)) u_fsm (
        .clk(clk), .pwr_a(pwr_ok_a), .dip_n(dip_n), .pwr_ok(pwr_ok), .bor_ok(bor_ok),
        .sys_rst(sys_rst), .bor_evt(bor_evt), .state_o(state));

    rstseq_status u_stat (
        .clk(clk), .pwr_a(pwr_ok_a), .bor_evt(bor_evt), .wr_en(stat_wr_en),
        .wr_data(stat_wr_data), .stat(stat_rd));

    a_r3_brownout_reset: assert property (@(posedge clk) disable iff (!pwr_ok_a)
        !bor_ok_a |-> sys_rst);
    a_r6_bor_source: assert property (@(posedge clk) disable iff (!pwr_ok_a)
        $rose(stat_rd[1]) |-> ($past(state) == ST_RUN || $past(state) == ST_PUP_TMR));
endmodule

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;
    localparam int TP = 3;
    localparam int TB = 2;
    localparam int TW = 4;

    logic       clk = 1'b0;
    logic       pwr_a, bor_a, wr_en;
    logic [1:0] wr_data;
    logic [1:0] rd;
    logic       sys_rst;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rstseq_top #(.T_POR(TP), .T_BOR(TB), .T_PWRT(TW)) u0 (
        .clk(clk), .pwr_ok_a(pwr_a), .bor_ok_a(bor_a), .stat_wr_en(wr_en),
        .stat_wr_data(wr_data), .stat_rd(rd), .sys_rst(sys_rst));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic measure(input int exp, input string tag);
        int n = 0;
        for (int i = 1; i <= 400; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!sys_rst) begin
                n = i;
                break;
            end
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic write(input logic [1:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        pwr_a = 1'b0; bor_a = 1'b0; wr_en = 1'b0; wr_data = 2'b00;
        @(negedge clk);
        steps(3);
        chk(sys_rst == 1'b1, "R1 reset held at power-up", sys_rst, 1);
        chk(rd == 2'b01, "R2 status after power-on", rd, 1);

        // R1: power-on release time
        bor_a = 1'b1;
        steps(4);
        pwr_a = 1'b1;
        measure(TP + TW + 3, "R1 power-on release");
        chk(rd == 2'b01, "R2 status kept after release", rd, 1);

        // R7: clear bit 0 only
        write(2'b10);
        chk(rd == 2'b00, "R7 write-zero clears", rd, 0);

        // R3 / R6 / R4: brown-out from RUN
        bor_a = 1'b0;
        #0.1;
        chk(sys_rst == 1'b1, "R3 immediate brown-out reset", sys_rst, 1);
        steps(2);
        chk(rd == 2'b10, "R6 brown-out bit set", rd, 2);
        bor_a = 1'b1;
        measure(TB + TW + 3, "R4 brown-out release");

        // R7: write of ones keeps, write of zero clears
        write(2'b11);
        chk(rd == 2'b10, "R7 write-one keeps", rd, 2);
        write(2'b01);
        chk(rd == 2'b00, "R7 clear brown-out bit", rd, 0);

        // R7: set beats a same-edge clear
        write(2'b11);
        bor_a = 1'b0;
        wr_en = 1'b1;
        wr_data = 2'b00;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd == 2'b10, "R7 set wins over clear", rd, 2);
        bor_a = 1'b1;
        measure(TB + TW + 3, "R4 release after set-wins");

        // R5 / R6 sweep of dip position across the restart chain
        for (int k = 1; k <= TB + TW + 1; k++) begin
            bor_a = 1'b0;
            steps(2);
            write(2'b01);
            bor_a = 1'b1;
            steps(k);
            bor_a = 1'b0;
            steps(1);
            bor_a = 1'b1;
            measure(TB + TW + 3, "R5 restart after dip");
            chk(rd[1] == (k >= TB + 2), "R6 re-set on dip in power-up timer",
                rd[1], (k >= TB + 2) ? 1 : 0);
        end

        // R9 / R2: power loss in RUN
        pwr_a = 1'b0;
        #0.1;
        chk(sys_rst == 1'b1, "R9 immediate power-on reset", sys_rst, 1);
        chk(rd == 2'b01, "R2 power loss sets bit0 clears bit1", rd, 1);
        steps(3);
        pwr_a = 1'b1;
        measure(TP + TW + 3, "R9 full power-on sequence");

        // R8: dip in PWR_WAIT during power-on episode
        pwr_a = 1'b0;
        bor_a = 1'b0;
        steps(2);
        bor_a = 1'b1;
        steps(3);
        pwr_a = 1'b1;
        steps(3);
        bor_a = 1'b0;
        steps(1);
        bor_a = 1'b1;
        measure(TP + TW + 3, "R8 power-on delay restarted");
        chk(rd == 2'b01, "R8 no brown-out bit in PWR_WAIT", rd, 1);

        // R8: dip in PUP_TMR during power-on episode
        pwr_a = 1'b0;
        steps(2);
        pwr_a = 1'b1;
        steps(TP + 3);
        bor_a = 1'b0;
        steps(1);
        bor_a = 1'b1;
        measure(TB + TW + 3, "R8 release after episode dip");
        chk(rd == 2'b01, "R8 no brown-out bit in power-up timer", rd, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule